// File: doc/BRIEF.md
# Prioritised Interrupt Controller Core

This block collects up to 32 external interrupt request lines, latches each one as pending on its rising edge, and forwards the most urgent enabled and pending line to a processor as an exception vector number. Software controls the block through a 32-bit register bus with byte offsets and word granularity. The enable mask and the pending set can each be changed bit by bit through separate set and clear aliases, so no read-modify-write sequence is needed. A 2-bit urgency level is held for every line.

The processor sees a request flag and a vector number. When it takes the interrupt, it pulses an acknowledge input. That pulse retires the pending bit of the line currently being reported. Every register access completes in the cycle it is presented. Read data is a combinational view of the current state. A write changes state at the clock edge that samples it.

Top module: `irqc_core`

## Requirements
- R1: After a synchronous active-low reset, the enable, pending and priority state are all zero, `core_req` is 0 and every register reads 0.
- R2: A write to byte offset 0x000 enables each line whose data bit is 1. Data bits that are 0 leave the line unchanged. A read of 0x000 returns the enable vector, with bit i for line i.
- R3: A write to offset 0x080 disables each line whose data bit is 1, and data bits that are 0 have no effect. A read of 0x080 also returns the enable vector.
- R4: A write to offset 0x100 makes each line with a 1 data bit pending. A write to offset 0x180 removes the pending state of each line with a 1 data bit. Zero bits have no effect. Reads of both offsets return the pending vector.
- R5: The priority word at offset 0x300+4k holds the level of line 4k+n in bits [8n+7:8n+6], for k = 0..7 and n = 0..3. All other bits of the word read 0 and ignore writes. Level 0 is the most urgent and level 3 the least.
- R6: A read of any other offset returns 0. A write to any other offset changes no state.
- R7: A 0-to-1 transition on `irq_in[i]`, sampled at a clock edge, sets pending bit i, even while line i is disabled. A line held high does not set the bit again after it has been cleared.
- R8: `core_req` is 1 exactly when at least one line is both enabled and pending.
- R9: While `core_req` is 1, `core_vector` equals 16 plus the index of the winner. The winner is the enabled, pending line with the lowest level; among equal levels, the lowest index wins. `core_vector` is 0 while `core_req` is 0.
- R10: `core_ack` sampled high while `core_req` is 1 clears only the winner's pending bit. `core_ack` while `core_req` is 0 has no effect.
- R11: When a pending clear (a write to 0x180 or an acknowledge) and a pending set (a rising edge on `irq_in`) hit the same bit in one cycle, the bit ends up cleared.
- R12: A write is visible on reads, `core_req` and `core_vector` from the cycle after the edge that samples it. Read data reflects the state in the same cycle the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_in | input | 32 | Interrupt request lines, synchronous to clk |
| core_ack | input | 1 | Processor takes the reported interrupt |
| core_req | output | 1 | An enabled, pending interrupt exists |
| core_vector | output | 8 | Vector number of the winner (line + 16) |

## Verification
Read data is due in the same cycle as the read. The bench therefore samples `bus_rdata` shortly after it drives a read at the falling edge, and compares it with its model state from before the next rising edge. Writes, request-line edges and acknowledges take effect at the next rising edge and appear on `core_req`, `core_vector` and reads one cycle later. The bench applies each of these at that rising edge in its model and compares the outputs at the following falling edge. Directed sequences cover alias behaviour, the placement of priority fields, tie-breaking, clear-over-set precedence and acknowledges. They are followed by seeded random bus traffic, line toggles and acknowledges.

// File: rtl/irqc_pkg.sv
// Package: shared constants and types for the interrupt controller core.
// Assumes a 10-bit byte-offset register bus with 32-bit words.
package irqc_pkg;

    // Register selected by a bus access
    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_EN_SET = 3'd1,
        SEL_EN_CLR = 3'd2,
        SEL_PD_SET = 3'd3,
        SEL_PD_CLR = 3'd4,
        SEL_PRIO   = 3'd5
    } reg_sel_e;

    // Word offsets (byte offset divided by four) of each register
    localparam int unsigned WORD_EN_SET = 32'h000;
    localparam int unsigned WORD_EN_CLR = 32'h020;
    localparam int unsigned WORD_PD_SET = 32'h040;
    localparam int unsigned WORD_PD_CLR = 32'h060;
    localparam int unsigned WORD_PRIO0  = 32'h0C0;

    // Lines per priority word and width of one byte lane
    localparam int unsigned LANES_PER_WORD = 4;
    localparam int unsigned LANE_W         = 8;

endpackage

// File: rtl/irqc_decode.sv
// Module: irqc_decode
// Turns a byte offset into a register select and a priority word index.
// Assumes word-aligned accesses; the two low address bits are ignored.
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned PRIO_WORDS = 8,
    localparam int unsigned PIDX_W    = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [PIDX_W-1:0] prio_idx
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] prio_off;
    logic              unused_low_bits;

    assign word            = addr[ADDR_W-1:2];
    assign unused_low_bits = ^addr[1:0];
    assign prio_off        = word - WORD_W'(WORD_PRIO0);
    assign prio_idx        = prio_off[PIDX_W-1:0];

    // Map the word offset onto one of the register aliases
    always_comb begin
        if (word == WORD_W'(WORD_EN_SET))      sel = SEL_EN_SET;
        else if (word == WORD_W'(WORD_EN_CLR)) sel = SEL_EN_CLR;
        else if (word == WORD_W'(WORD_PD_SET)) sel = SEL_PD_SET;
        else if (word == WORD_W'(WORD_PD_CLR)) sel = SEL_PD_CLR;
        else if (word >= WORD_W'(WORD_PRIO0) &&
                 word <  WORD_W'(WORD_PRIO0 + PRIO_WORDS)) sel = SEL_PRIO;
        else                                   sel = SEL_NONE;
    end

endmodule

// File: rtl/irqc_edge.sv
// Module: irqc_edge
// Detects 0-to-1 transitions on each request line.
// Assumes the lines are already synchronous to clk.
module irqc_edge #(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic [NUM_IRQ-1:0] rise
);
    logic [NUM_IRQ-1:0] irq_q;

    // Remember the previous level of each line
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_in;
    end

    assign rise = irq_in & ~irq_q;

endmodule

// File: rtl/irqc_state.sv
// Module: irqc_state
// Holds the enable, pending and priority state and serves the register bus.
// Assumes one access per cycle and no wait states. Clears beat sets on pending bits.
module irqc_state
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IRQ    = 32,
    parameter int unsigned PRIO_W     = 2,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned PRIO_WORDS = (NUM_IRQ + 3) / 4,
    localparam int unsigned PIDX_W    = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  reg_sel_e                  sel,
    input  logic [PIDX_W-1:0]         prio_idx,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [NUM_IRQ-1:0]        hw_set,
    input  logic [NUM_IRQ-1:0]        hw_clr,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_IRQ-1:0]        en_vec,
    output logic [NUM_IRQ-1:0]        pend_vec,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_flat
);
    logic [NUM_IRQ-1:0] en_q;
    logic [NUM_IRQ-1:0] pend_q;
    logic [PRIO_W-1:0]  prio_q [NUM_IRQ];
    logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr;
    logic [NUM_IRQ-1:0] pd_clr_all, pd_set_all;
    logic               prio_wr;
    logic [DATA_W-1:0]  prio_word;

    // Per-bit masks for each alias write
    assign en_set  = (wr_en && sel == SEL_EN_SET) ? wdata[NUM_IRQ-1:0] : '0;
    assign en_clr  = (wr_en && sel == SEL_EN_CLR) ? wdata[NUM_IRQ-1:0] : '0;
    assign pd_set  = (wr_en && sel == SEL_PD_SET) ? wdata[NUM_IRQ-1:0] : '0;
    assign pd_clr  = (wr_en && sel == SEL_PD_CLR) ? wdata[NUM_IRQ-1:0] : '0;
    assign prio_wr = wr_en && sel == SEL_PRIO;

    assign pd_set_all = pd_set | hw_set;
    assign pd_clr_all = pd_clr | hw_clr;

    // Enable vector: set and clear aliases
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | en_set) & ~en_clr;
    end

    // Pending vector: clears take precedence over sets in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | pd_set_all) & ~pd_clr_all;
    end

    // Priority fields: line i lives in the top bits of lane i%4 of word i/4
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
        localparam int unsigned TOP = (i % LANES_PER_WORD) * LANE_W + LANE_W - 1;
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[i] <= '0;
            else if (prio_wr && prio_idx == PIDX_W'(i / LANES_PER_WORD))
                prio_q[i] <= wdata[TOP -: PRIO_W];
        end
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end

    // Assemble the selected priority word; unused bits read zero
    always_comb begin
        prio_word = '0;
        for (int n = 0; n < int'(LANES_PER_WORD); n++) begin
            if (int'(prio_idx) * int'(LANES_PER_WORD) + n < int'(NUM_IRQ))
                prio_word[n*LANE_W + LANE_W - 1 -: PRIO_W] =
                    prio_q[int'(prio_idx) * int'(LANES_PER_WORD) + n];
        end
    end

    // Read multiplexer: both aliases of a vector return its current value
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_EN_SET, SEL_EN_CLR: rdata[NUM_IRQ-1:0] = en_q;
            SEL_PD_SET, SEL_PD_CLR: rdata[NUM_IRQ-1:0] = pend_q;
            SEL_PRIO:               rdata = prio_word;
            default:                rdata = '0;
        endcase
    end

    assign en_vec   = en_q;
    assign pend_vec = pend_q;

    // R2
    en_set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_set) |=> ((en_q & $past(en_set)) == $past(en_set)));

    // R3
    en_clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_clr) |=> ((en_q & $past(en_clr)) == '0));

    // R11
    pend_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pd_clr_all) |=> ((pend_q & $past(pd_clr_all)) == '0));

    // R7
    pend_set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pd_set_all & ~pd_clr_all)) |=>
        ((pend_q & $past(pd_set_all & ~pd_clr_all)) == $past(pd_set_all & ~pd_clr_all)));

endmodule

// File: rtl/irqc_arbiter.sv
// Module: irqc_arbiter
// Picks the active line with the lowest priority value, lowest index on ties.
// Assumes active = enabled AND pending; purely combinational.
module irqc_arbiter #(
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned PRIO_W  = 2,
    localparam int unsigned IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0]        active,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      any,
    output logic [IDX_W-1:0]          win_idx
);
    logic [PRIO_W-1:0] best_prio;

    // Linear scan; strict compare keeps the lowest index among equals
    always_comb begin
        any       = 1'b0;
        win_idx   = '0;
        best_prio = '1;
        for (int i = 0; i < int'(NUM_IRQ); i++) begin
            if (active[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
                any       = 1'b1;
                win_idx   = IDX_W'(i);
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irqc_core.sv
// Module: irqc_core
// Top level: register bus, edge capture, state and winner selection.
// Assumes synchronous request lines and a single-cycle acknowledge pulse.
module irqc_core
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IRQ  = 32,
    parameter int unsigned PRIO_W   = 2,
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic              core_ack,
    output logic              core_req,
    output logic [VEC_W-1:0]  core_vector
);
    localparam int unsigned PRIO_WORDS = (NUM_IRQ + LANES_PER_WORD - 1) / LANES_PER_WORD;
    localparam int unsigned PIDX_W     = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1;
    localparam int unsigned IDX_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    reg_sel_e                  sel;
    logic [PIDX_W-1:0]         prio_idx;
    logic [NUM_IRQ-1:0]        rise;
    logic [NUM_IRQ-1:0]        ack_clr;
    logic [NUM_IRQ-1:0]        en_vec, pend_vec;
    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic [DATA_W-1:0]         rd_raw;
    logic                      any;
    logic [IDX_W-1:0]          win_idx;

    irqc_decode #(.ADDR_W(ADDR_W), .PRIO_WORDS(PRIO_WORDS)) u_decode (
        .addr(bus_addr), .sel(sel), .prio_idx(prio_idx)
    );

    irqc_edge #(.NUM_IRQ(NUM_IRQ)) u_edge (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise)
    );

    irqc_state #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
                 .PRIO_WORDS(PRIO_WORDS)) u_state (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_en && bus_we), .sel(sel),
        .prio_idx(prio_idx), .wdata(bus_wdata), .hw_set(rise), .hw_clr(ack_clr),
        .rdata(rd_raw), .en_vec(en_vec), .pend_vec(pend_vec), .prio_flat(prio_flat)
    );

    irqc_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
        .active(en_vec & pend_vec), .prio_flat(prio_flat), .any(any), .win_idx(win_idx)
    );

    // Acknowledge retires only the line currently reported
    always_comb begin
        ack_clr = '0;
        if (core_ack && any) ack_clr[win_idx] = 1'b1;
    end

    // Present read data only during a read access
    assign bus_rdata   = (bus_en && !bus_we) ? rd_raw : '0;
    assign core_req    = any;
    assign core_vector = any ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx)) : '0;

    // R8
    req_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> (en_vec[win_idx] && pend_vec[win_idx]));

    // R10
    ack_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack && core_req) |=> !pend_vec[$past(win_idx)]);

endmodule

// File: tb/irqc_core_bench.sv
module irqc_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        core_ack = 1'b0;
    logic        core_req;
    logic [7:0]  core_vector;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model
    logic [31:0] m_en = '0, m_pend = '0, m_irq_prev = '0;
    logic [1:0]  m_pri [32];

    always #5 clk = ~clk;

    irqc_core u_irqc_core (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .core_ack(core_ack), .core_req(core_req),
        .core_vector(core_vector)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int m_winner();
        int w = -1;
        for (int i = 0; i < 32; i++)
            if (m_en[i] && m_pend[i] && (w < 0 || m_pri[i] < m_pri[w])) w = i;
        return w;
    endfunction

    function automatic logic [31:0] m_read(input logic [9:0] a);
        logic [7:0] w = a[9:2];
        logic [31:0] r = '0;
        if (w == 8'h00 || w == 8'h20) r = m_en;
        else if (w == 8'h40 || w == 8'h60) r = m_pend;
        else if (w >= 8'hC0 && w <= 8'hC7)
            for (int n = 0; n < 4; n++) r[n*8+6 +: 2] = m_pri[(w - 8'hC0) * 4 + n];
        return r;
    endfunction

    task automatic m_step(input logic wr, input logic [9:0] a, input logic [31:0] d,
                          input logic [31:0] irq, input logic ack);
        logic [7:0]  w = a[9:2];
        logic [31:0] rise = irq & ~m_irq_prev;
        logic [31:0] ackv = '0;
        logic [31:0] ps = rise, pc = '0, es = '0, ec = '0;
        int win = m_winner();
        if (ack && win >= 0) ackv[win] = 1'b1;
        if (wr) begin
            if (w == 8'h00) es = d;
            if (w == 8'h20) ec = d;
            if (w == 8'h40) ps = ps | d;
            if (w == 8'h60) pc = d;
            if (w >= 8'hC0 && w <= 8'hC7)
                for (int n = 0; n < 4; n++) m_pri[(w - 8'hC0) * 4 + n] = d[n*8+6 +: 2];
        end
        m_en       = (m_en | es) & ~ec;
        m_pend     = (m_pend | ps) & ~(pc | ackv);
        m_irq_prev = irq;
    endtask

    // One bus cycle: drive at falling edge, check reads at once, outputs after the edge
    task automatic cyc(input logic en, input logic we, input logic [9:0] a,
                       input logic [31:0] d, input logic ack, input string tag);
        int win;
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; core_ack = ack;
        #1;
        if (en && !we) check(tag, bus_rdata, m_read(a));
        m_step(en && we, a, d, irq_in, ack);
        @(negedge clk);
        win = m_winner();
        check("R8 request", {31'b0, core_req}, {31'b0, win >= 0});
        check("R9 vector", {24'b0, core_vector}, (win >= 0) ? 32'(win + 16) : 32'd0);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, 1'b1, a, d, 1'b0, tag);
    endtask

    task automatic rd(input logic [9:0] a, input string tag);
        cyc(1'b1, 1'b0, a, '0, 1'b0, tag);
    endtask

    task automatic idle(input logic ack);
        cyc(1'b0, 1'b0, '0, '0, ack, "R10 idle");
    endtask

    function automatic logic [9:0] pick_addr(input int k);
        case (k % 14)
            0: return 10'h000;
            1: return 10'h080;
            2: return 10'h100;
            3: return 10'h180;
            12: return 10'h200;
            13: return 10'h3A0;
            default: return 10'(10'h300 + 4 * ((k % 14) - 4));
        endcase
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_pri[i] = 2'd0;
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything reads zero after reset
        rd(10'h000, "R1 enable");
        rd(10'h100, "R1 pending");
        rd(10'h31C, "R1 priority");
        check("R1 request", {31'b0, core_req}, 32'd0);

        // R2: set alias, zeros ignored; R12 visible next cycle
        wr(10'h000, 32'h0000_02F0, "R2");
        rd(10'h000, "R12 enable visible next cycle");
        wr(10'h000, 32'h0, "R2");
        rd(10'h000, "R2 zeros no effect");

        // R3: clear alias, read through both aliases
        wr(10'h080, 32'h0000_0010, "R3");
        rd(10'h080, "R3 clear alias read");
        rd(10'h000, "R3 set alias read");

        // R4: pending set and clear aliases
        wr(10'h100, 32'h8000_0041, "R4");
        rd(10'h180, "R4 clear alias read");
        wr(10'h180, 32'h0000_0001, "R4");
        rd(10'h100, "R4 after clear");
        wr(10'h180, 32'h8000_0040, "R4");

        // R5: priority field placement
        wr(10'h304, 32'hFFFF_FFFF, "R5");
        rd(10'h304, "R5 only top bits of lanes");
        wr(10'h304, 32'h0000_0000, "R5");

        // R6: unmapped offsets
        wr(10'h200, 32'hFFFF_FFFF, "R6");
        rd(10'h200, "R6 unmapped read");
        rd(10'h320, "R6 past priority words");
        rd(10'h000, "R6 enable untouched");

        // R7: rising edge on disabled line 3 sets pending; steady level does not re-set
        irq_in[3] = 1'b1;
        idle(1'b0);
        rd(10'h100, "R7 edge on disabled line");
        wr(10'h180, 32'h0000_0008, "R7");
        idle(1'b0);
        rd(10'h100, "R7 level does not re-set");
        irq_in[3] = 1'b0;
        idle(1'b0);

        // R11: edge and pending clear on the same bit in one cycle
        irq_in[4] = 1'b1;
        wr(10'h180, 32'h0000_0010, "R11");
        rd(10'h100, "R11 clear wins over edge");
        irq_in[4] = 1'b0;

        // R9: levels and ties between lines 5 and 9
        wr(10'h000, 32'h0000_0220, "R9");
        wr(10'h304, 32'h0000_8000, "R9");
        wr(10'h308, 32'h0000_4000, "R9");
        wr(10'h100, 32'h0000_0220, "R9 line 9 wins");
        wr(10'h308, 32'h0000_8000, "R9 tie lowest index");

        // R10: acknowledge retires the winner only
        idle(1'b1);
        rd(10'h100, "R10 winner cleared");
        wr(10'h080, 32'hFFFF_FFFF, "R10");
        wr(10'h100, 32'h0000_0001, "R10");
        idle(1'b1);
        rd(10'h100, "R10 ack without request");

        // R11: acknowledge and edge on the winner in one cycle
        wr(10'h000, 32'h0000_0001, "R11");
        irq_in[0] = 1'b1;
        idle(1'b1);
        rd(10'h100, "R11 ack wins over edge");
        irq_in[0] = 1'b0;

        // Seeded random traffic
        for (int t = 0; t < 4000; t++) begin
            int op = int'($urandom % 8);
            logic [9:0] a = pick_addr(int'($urandom % 14));
            logic [31:0] d = $urandom;
            if (a == 10'h080 || a == 10'h180) d = d & $urandom;
            irq_in = irq_in ^ ($urandom & $urandom & $urandom);
            if (op == 0)      cyc(1'b0, 1'b0, a, d, ($urandom % 4) == 0, "R10 random ack");
            else if (op < 6)  cyc(1'b1, 1'b1, a, d, ($urandom % 4) == 0, "R12 random write");
            else              cyc(1'b1, 1'b0, a, d, ($urandom % 4) == 0, "R12 random read");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule